// File: doc/BRIEF.md
# Keyed Full-Cycle Watermark Sequence Generator

This block produces a pseudorandom watermark stream for a spatial-domain image watermarking datapath. An 8-bit shift register with one-to-many feedback steps through a sequence selected by a secret seed. Extra zero-detect logic lets the sequence pass through the all-zero value, so one cycle visits all 256 register values and no value can trap the generator.

The seed and the number of advance steps together form the watermark key. An embedder and a detector that load the same seed and advance the same number of times see the same register value, and therefore the same watermark. Two small maps turn the register into watermark symbols. One gives a binary bit for bit-plane (fragile) marking. The other gives a three-level symbol for neighbourhood-based (robust) marking.

Top module: `wm_keyed_lfsr`

## Requirements
- R1: While reset is held, and until the first clock edge after reset has been released internally, the register reads 8'h01, the binary bit reads 1 and the ternary symbol reads 1.
- R2: When seed_load is high at a clock edge, the register takes seed_key at that edge, whether or not adv_en is high.
- R3: When seed_load and adv_en are both low at a clock edge, the register keeps its value.
- R4: When adv_en is high and seed_load is low, the register becomes (s<<1 mod 256) XOR (f ? 8'h71 : 8'h00), where f = s[7] XOR (s[6:0]==0). This sends 8'h80 to 8'h00 and 8'h00 to 8'h71, and every other value follows the polynomial x^8+x^6+x^5+x^4+1.
- R5: Starting from any value, 256 advances visit each of the 256 register values exactly once and then return to the start value.
- R6: wm_bit always equals bit 0 of the register.
- R7: wm_sym always equals register bits 1:0 taken modulo 3: 2'b00 gives 0, 2'b01 gives 1, 2'b10 gives 2 and 2'b11 gives 0. It never reads 3.
- R8: Loading the same seed and advancing the same number of times yields the same register value, however many hold cycles are placed between the advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seed_load | input | 1 | Load seed_key into the register at the next edge |
| seed_key | input | 8 | Watermark key seed |
| adv_en | input | 1 | Advance the sequence by one step |
| lfsr_q | output | 8 | Current register value |
| wm_bit | output | 1 | Binary watermark bit |
| wm_sym | output | 2 | Ternary watermark symbol, 0 to 2 |

## Verification
The hardest situation to reach is the pair of steps through the all-zero value. From the reset value it takes many advances to arrive there, and an ordinary shift register never arrives at all. The stimulus therefore seeds 8'h80 and 8'h00 directly, then walks one full 256-step loop from zero. During that loop it marks every value it sees, which shows that no value repeats before the loop closes.

// File: rtl/wm_lfsr_pkg.sv
package wm_lfsr_pkg;

  localparam int unsigned WM_W   = 8;
  localparam int unsigned SYM_W  = 2;

  // Three-level watermark symbol
  typedef enum logic [SYM_W-1:0] {
    SYM_KEEP = 2'd0,
    SYM_ADD  = 2'd1,
    SYM_SUB  = 2'd2
  } wm_sym_e;

  // Two-bit value folded modulo three
  function automatic wm_sym_e fold_mod3(input logic [SYM_W-1:0] v);
    wm_sym_e r;
    case (v)
      2'd1:    r = SYM_ADD;
      2'd2:    r = SYM_SUB;
      default: r = SYM_KEEP;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wm_rst_sync.sv
module wm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[STAGES-1];

endmodule

// File: rtl/wm_lfsr_core.sv
module wm_lfsr_core #(
  parameter int unsigned        WIDTH     = 8,
  parameter logic [WIDTH-1:0]   TAP_MASK  = 8'h71,
  parameter logic [WIDTH-1:0]   RST_VALUE = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic             step_i,
  output logic [WIDTH-1:0] state_o
);

  localparam int unsigned LOW_W = WIDTH - 1;

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] stepped;
  logic             low_zero;
  logic             feed;
  logic             upd_en;

  // Zero-insert correction: low bits all clear flips the feedback
  assign low_zero = ~|state_q[LOW_W-1:0];
  assign feed     = state_q[WIDTH-1] ^ low_zero;
  assign shifted  = {state_q[LOW_W-1:0], 1'b0};

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_tap
      if (TAP_MASK[gi]) begin : g_xor
        assign stepped[gi] = shifted[gi] ^ feed;
      end else begin : g_pass
        assign stepped[gi] = shifted[gi];
      end
    end
  endgenerate

  assign upd_en = load_i | step_i;

  always_comb begin
    state_d = state_q;
    if (load_i)      state_d = seed_i;
    else if (step_i) state_d = stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= RST_VALUE;
    else if (upd_en) state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/wm_symbol_map.sv
module wm_symbol_map
  import wm_lfsr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] state_i,
  output logic             bit_o,
  output logic [SYM_W-1:0] sym_o
);

  wm_sym_e sym;

  always_comb begin
    sym = fold_mod3(state_i[SYM_W-1:0]);
  end

  assign bit_o = state_i[0];
  assign sym_o = sym;

endmodule

// File: rtl/wm_keyed_lfsr.sv
module wm_keyed_lfsr
  import wm_lfsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            seed_load,
  input  logic [WM_W-1:0] seed_key,
  input  logic            adv_en,
  output logic [WM_W-1:0] lfsr_q,
  output logic            wm_bit,
  output logic [1:0]      wm_sym
);

  logic rst_core_n;

  wm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  wm_lfsr_core #(
    .WIDTH     (WM_W),
    .TAP_MASK  (8'h71),
    .RST_VALUE (8'h01)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load_i  (seed_load),
    .seed_i  (seed_key),
    .step_i  (adv_en),
    .state_o (lfsr_q)
  );

  wm_symbol_map #(.WIDTH(WM_W)) u_map (
    .state_i (lfsr_q),
    .bit_o   (wm_bit),
    .sym_o   (wm_sym)
  );

endmodule

// File: rtl/wm_keyed_lfsr_chk.sv
module wm_keyed_lfsr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       seed_load,
  input logic [7:0] seed_key,
  input logic       adv_en,
  input logic [7:0] lfsr_q,
  input logic       wm_bit,
  input logic [1:0] wm_sym
);

  a_r2_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> lfsr_q == $past(seed_key));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_load && !adv_en) |=> $stable(lfsr_q));

  a_r4_enter_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !seed_load && lfsr_q == 8'h80) |=> lfsr_q == 8'h00);

  a_r4_leave_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !seed_load && lfsr_q == 8'h00) |=> lfsr_q == 8'h71);

  a_r6_bit: assert property (@(posedge clk) disable iff (!rst_n)
    wm_bit == lfsr_q[0]);

  a_r7_no_three: assert property (@(posedge clk) disable iff (!rst_n)
    wm_sym != 2'd3);

endmodule

bind wm_keyed_lfsr wm_keyed_lfsr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .seed_load (seed_load),
  .seed_key  (seed_key),
  .adv_en    (adv_en),
  .lfsr_q    (lfsr_q),
  .wm_bit    (wm_bit),
  .wm_sym    (wm_sym)
);

// File: tb/wm_keyed_lfsr_tb.sv
module wm_keyed_lfsr_tb;

  logic       clk;
  logic       rst_n;
  logic       seed_load;
  logic [7:0] seed_key;
  logic       adv_en;
  logic [7:0] lfsr_q;
  logic       wm_bit;
  logic [1:0] wm_sym;

  int n_checks;
  int n_fails;
  bit done;

  wm_keyed_lfsr u_dut (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_key(seed_key),
    .adv_en(adv_en), .lfsr_q(lfsr_q), .wm_bit(wm_bit), .wm_sym(wm_sym)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // seed, expected value after one advance (R4)
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    {8'h01, 8'h02}, {8'h80, 8'h00}, {8'h00, 8'h71}, {8'h71, 8'hE2},
    {8'hE2, 8'hB5}, {8'hB5, 8'h1B}, {8'hFF, 8'h8F}, {8'h40, 8'h80}
  };

  // Recurrence from R4
  function automatic logic [7:0] model_step(input logic [7:0] s);
    logic f;
    f = s[7] ^ (s[6:0] == 7'd0);
    return {s[6:0], 1'b0} ^ (f ? 8'h71 : 8'h00);
  endfunction

  function automatic logic [1:0] model_sym(input logic [7:0] s);
    return (s[1:0] == 2'd3) ? 2'd0 : s[1:0];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, one posedge, sample at next negedge
  task automatic cyc(input logic ld, input logic [7:0] key, input logic adv);
    seed_load = ld; seed_key = key; adv_en = adv;
    @(negedge clk);
    seed_load = 1'b0; adv_en = 1'b0;
  endtask

  initial begin
    #1500000;
    n_checks++; n_fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  logic [7:0] rec;
  logic [7:0] ex;
  bit seen [256];
  int dup;

  initial begin
    n_checks = 0; n_fails = 0;
    rst_n = 1'b0; seed_load = 1'b0; seed_key = 8'h00; adv_en = 1'b0;
    @(negedge clk); @(negedge clk);
    // R1 during reset, with load requested
    seed_load = 1'b1; seed_key = 8'hAA;
    @(negedge clk);
    check("R1 reset state", lfsr_q, 8'h01);
    check("R1 reset bit", {7'd0, wm_bit}, 8'h01);
    check("R1 reset sym", {6'd0, wm_sym}, 8'h01);
    seed_load = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", lfsr_q, 8'h01);

    // Vector table: R2 load then R4 step, with R6/R7 maps
    for (int i = 0; i < NV; i++) begin
      cyc(1'b1, VEC[i][15:8], 1'b0);
      check("R2 load", lfsr_q, VEC[i][15:8]);
      cyc(1'b0, 8'h00, 1'b1);
      check("R4 step", lfsr_q, VEC[i][7:0]);
      check("R6 bit", {7'd0, wm_bit}, {7'd0, VEC[i][0]});
      check("R7 sym", {6'd0, wm_sym}, {6'd0, model_sym(VEC[i][7:0])});
    end

    // R7 all four low-bit codes
    for (int v = 0; v < 4; v++) begin
      cyc(1'b1, 8'(v) | 8'hC4 & 8'hFC, 1'b0);
      check("R7 mod3", {6'd0, wm_sym}, {6'd0, model_sym(8'(v))});
    end

    // R2 load wins over advance
    cyc(1'b1, 8'h3C, 1'b1);
    check("R2 priority", lfsr_q, 8'h3C);

    // R3 hold for several cycles, seed_key toggling
    for (int h = 0; h < 5; h++) begin
      cyc(1'b0, 8'(h * 37), 1'b0);
      check("R3 hold", lfsr_q, 8'h3C);
    end

    // R5 full loop from zero
    for (int k = 0; k < 256; k++) seen[k] = 1'b0;
    dup = 0;
    cyc(1'b1, 8'h00, 1'b0);
    ex = 8'h00;
    for (int k = 0; k < 256; k++) begin
      if (seen[lfsr_q]) dup++;
      seen[lfsr_q] = 1'b1;
      cyc(1'b0, 8'h00, 1'b1);
      ex = model_step(ex);
      if (k < 255 && lfsr_q == 8'h00) dup++;
    end
    check("R5 no repeat", 8'(dup), 8'h00);
    check("R5 return", lfsr_q, 8'h00);
    check("R5 model track", lfsr_q, ex);

    // R8 replay: 37 advances, then again with holds between
    cyc(1'b1, 8'h5A, 1'b0);
    for (int k = 0; k < 37; k++) cyc(1'b0, 8'h00, 1'b1);
    rec = lfsr_q;
    ex = 8'h5A;
    for (int k = 0; k < 37; k++) ex = model_step(ex);
    check("R8 first run", rec, ex);
    cyc(1'b1, 8'h5A, 1'b0);
    for (int k = 0; k < 37; k++) begin
      cyc(1'b0, 8'h00, 1'b1);
      if (k % 3 == 0) cyc(1'b0, 8'hFF, 1'b0);
    end
    check("R8 replay", lfsr_q, rec);

    // R1 reset mid-run returns to 01
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 async reset", lfsr_q, 8'h01);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule